// File: doc/BRIEF.md
# Maintenance Message Transmit Scheduler

This block decides when a path-maintenance message leaves the transmitter and how many bytes it carries. A host programs a small configuration register holding an enable bit, a length-select bit and a repeat-mode bit. It then issues a send command. The block turns that command into a one-cycle start request to a downstream message serializer and presents a byte count alongside it. After that it waits for the serializer to report completion.

In one-shot mode a single message goes out per send command. In repeat mode the message is sent again on every one-second tick until the host clears the enable bit. If a tick arrives while a message is still in flight, one retransmission is held pending and launched as soon as the current message completes. A sticky completion flag is set at the end of each message and is cleared when the host reads the status register.

Top module: `lapd_tx_sched`

## Requirements
- R1: After reset the configuration register (address 0x33) reads 0x08: repeat mode on, enable off, short length. The start output is low and the completion flag is 0.
- R2: In the configuration register, bit 0 is enable, bit 1 is long length and bit 3 is repeat mode. Bits 7:4 and bit 2 always read 0, whatever value was written.
- R3: While enable is 0, a send command produces no start request.
- R4: With enable at 1, a send command in IDLE raises `ser_start` for exactly one cycle, in the cycle after the command. `ser_len` then shows 76 when bit 1 is 0 and 82 when bit 1 is 1. The count is held until the message completes.
- R5: In one-shot mode (bit 3 = 0), after completion no tick causes another start until a new send command arrives.
- R6: In repeat mode, after completion the next one-second tick starts a new message in the following cycle.
- R7: Ticks that arrive while a message is in flight record one pending retransmission, however many ticks there are. That retransmission starts in the cycle right after completion.
- R8: Clearing enable cancels a pending retransmission at once. A message already in flight still completes and sets the completion flag, and no further start follows.
- R9: The status register (address 0x34) has bit 0 as the completion flag and bit 1 as busy. The flag is set in the cycle after `ser_done` and cleared by a status read.
- R10: A send command that arrives while a message is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status reads clear the completion flag) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| send_cmd | input | 1 | Host send command pulse |
| sec_tick | input | 1 | One-second tick pulse |
| ser_busy | input | 1 | Serializer busy, reflected in status |
| ser_done | input | 1 | Serializer completion pulse |
| ser_start | output | 1 | One-cycle start request to the serializer |
| ser_len | output | 7 | Message byte count for the serializer |
| done_flag | output | 1 | Sticky completion flag |

## Verification
On every cycle the assertions check four things. Each start request lasts one cycle and is preceded by enable. The byte count is legal and stays stable while a message is in flight. Completion always raises the flag, and disable always clears the pending retransmission. Other behaviours depend on a sequence of events, and only the bench scenarios show them. These are one-shot versus repeat behaviour after completion, the coalescing of several ticks into one retransmission, the timing of a retransmission launched straight from completion, and send commands being ignored while disabled or busy.

// File: rtl/lapd_sched_pkg.sv
package lapd_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2,
        ST_WAIT  = 2'd3
    } sched_state_t;

    typedef struct packed {
        logic auto_rpt;
        logic long_msg;
        logic en;
    } sched_cfg_t;

endpackage

// File: rtl/lapd_cfg_regs.sv
module lapd_cfg_regs
    import lapd_sched_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter logic [7:0]  CFG_ADDR  = 8'h33,
    parameter logic [7:0]  STAT_ADDR = 8'h34,
    parameter logic        RST_AUTO  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              done_evt,
    input  logic              busy,
    output sched_cfg_t        cfg,
    output logic              done_flag
);
    localparam int BIT_EN   = 0;
    localparam int BIT_LONG = 1;
    localparam int BIT_AUTO = 3;
    localparam int BIT_DONE = 0;
    localparam int BIT_BUSY = 1;

    typedef struct packed {
        sched_cfg_t cfg;
        logic       done;
    } regs_t;

    regs_t regs_d, regs_q;

    logic cfg_sel, stat_sel;
    assign cfg_sel  = (reg_addr == CFG_ADDR[ADDR_W-1:0]);
    assign stat_sel = (reg_addr == STAT_ADDR[ADDR_W-1:0]);

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[DATA_W-1:BIT_AUTO+1], reg_wdata[2]};

    always_comb begin
        regs_d = regs_q;
        if (reg_wr && cfg_sel) begin
            regs_d.cfg.en       = reg_wdata[BIT_EN];
            regs_d.cfg.long_msg = reg_wdata[BIT_LONG];
            regs_d.cfg.auto_rpt = reg_wdata[BIT_AUTO];
        end
        if (reg_rd && stat_sel) begin
            regs_d.done = 1'b0;
        end
        if (done_evt) begin
            regs_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.cfg.en       <= 1'b0;
            regs_q.cfg.long_msg <= 1'b0;
            regs_q.cfg.auto_rpt <= RST_AUTO;
            regs_q.done         <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (cfg_sel) begin
            reg_rdata[BIT_EN]   = regs_q.cfg.en;
            reg_rdata[BIT_LONG] = regs_q.cfg.long_msg;
            reg_rdata[BIT_AUTO] = regs_q.cfg.auto_rpt;
        end else if (stat_sel) begin
            reg_rdata[BIT_DONE] = regs_q.done;
            reg_rdata[BIT_BUSY] = busy;
        end
    end

    assign cfg       = regs_q.cfg;
    assign done_flag = regs_q.done;

endmodule

// File: rtl/lapd_sched_fsm.sv
module lapd_sched_fsm
    import lapd_sched_pkg::*;
#(
    parameter int LEN_SHORT = 76,
    parameter int LEN_LONG  = 82,
    parameter int LEN_W     = $clog2(LEN_LONG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sched_cfg_t       cfg,
    input  logic             send_cmd,
    input  logic             sec_tick,
    input  logic             ser_done,
    output logic             ser_start,
    output logic [LEN_W-1:0] ser_len,
    output logic             done_evt,
    output logic             active,
    output sched_state_t     state,
    output logic             pend
);
    localparam logic [LEN_W-1:0] LEN_S = LEN_W'(LEN_SHORT);
    localparam logic [LEN_W-1:0] LEN_L = LEN_W'(LEN_LONG);

    typedef struct packed {
        sched_state_t     state;
        logic             pend;
        logic [LEN_W-1:0] len;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic             in_flight;
    logic             pend_hit;
    logic [LEN_W-1:0] sel_len;

    assign in_flight = (fsm_q.state == ST_SEND) || (fsm_q.state == ST_WAIT);
    assign pend_hit  = sec_tick && cfg.en && cfg.auto_rpt && in_flight;
    assign sel_len   = cfg.long_msg ? LEN_L : LEN_S;

    always_comb begin
        fsm_d    = fsm_q;
        done_evt = 1'b0;
        if (pend_hit) begin
            fsm_d.pend = 1'b1;
        end
        case (fsm_q.state)
            ST_IDLE: begin
                if (send_cmd && cfg.en) begin
                    fsm_d.state = ST_SEND;
                    fsm_d.len   = sel_len;
                end
            end
            ST_ARMED: begin
                if (!cfg.en || !cfg.auto_rpt) begin
                    fsm_d.state = ST_IDLE;
                end else if (sec_tick) begin
                    fsm_d.state = ST_SEND;
                    fsm_d.len   = sel_len;
                end
            end
            ST_SEND: begin
                fsm_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (ser_done) begin
                    done_evt = 1'b1;
                    if (cfg.en && fsm_d.pend) begin
                        fsm_d.state = ST_SEND;
                        fsm_d.pend  = 1'b0;
                        fsm_d.len   = sel_len;
                    end else if (cfg.en && cfg.auto_rpt) begin
                        fsm_d.state = ST_ARMED;
                    end else begin
                        fsm_d.state = ST_IDLE;
                    end
                end
            end
            default: fsm_d.state = ST_IDLE;
        endcase
        if (!cfg.en) begin
            fsm_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.state <= ST_IDLE;
            fsm_q.pend  <= 1'b0;
            fsm_q.len   <= LEN_S;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign ser_start = (fsm_q.state == ST_SEND);
    assign ser_len   = fsm_q.len;
    assign active    = in_flight;
    assign state     = fsm_q.state;
    assign pend      = fsm_q.pend;

endmodule

// File: rtl/lapd_tx_sched.sv
module lapd_tx_sched
    import lapd_sched_pkg::*;
#(
    parameter int         LEN_SHORT = 76,
    parameter int         LEN_LONG  = 82,
    parameter logic [7:0] CFG_ADDR  = 8'h33,
    parameter logic [7:0] STAT_ADDR = 8'h34,
    parameter int         LEN_W     = $clog2(LEN_LONG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             send_cmd,
    input  logic             sec_tick,
    input  logic             ser_busy,
    input  logic             ser_done,
    output logic             ser_start,
    output logic [LEN_W-1:0] ser_len,
    output logic             done_flag
);
    sched_cfg_t   cfg;
    sched_state_t fsm_state;
    logic         fsm_pend;
    logic         done_evt;
    logic         fsm_active;
    logic         cfg_en;

    assign cfg_en = cfg.en;

    lapd_cfg_regs #(
        .ADDR_W    (8),
        .DATA_W    (8),
        .CFG_ADDR  (CFG_ADDR),
        .STAT_ADDR (STAT_ADDR),
        .RST_AUTO  (1'b1)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .done_evt  (done_evt),
        .busy      (fsm_active | ser_busy),
        .cfg       (cfg),
        .done_flag (done_flag)
    );

    lapd_sched_fsm #(
        .LEN_SHORT (LEN_SHORT),
        .LEN_LONG  (LEN_LONG),
        .LEN_W     (LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .send_cmd  (send_cmd),
        .sec_tick  (sec_tick),
        .ser_done  (ser_done),
        .ser_start (ser_start),
        .ser_len   (ser_len),
        .done_evt  (done_evt),
        .active    (fsm_active),
        .state     (fsm_state),
        .pend      (fsm_pend)
    );

endmodule

// File: rtl/lapd_tx_sched_chk.sv
module lapd_tx_sched_chk
    import lapd_sched_pkg::*;
#(
    parameter int LEN_SHORT = 76,
    parameter int LEN_LONG  = 82,
    parameter int LEN_W     = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input sched_state_t     state,
    input logic             pend,
    input logic             ser_start,
    input logic             ser_done,
    input logic [LEN_W-1:0] ser_len,
    input logic             done_flag
);
    p_start_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |=> !ser_start);

    p_start_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |-> $past(en));

    p_len_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |-> (ser_len == LEN_W'(LEN_SHORT) || ser_len == LEN_W'(LEN_LONG)));

    p_len_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> $stable(ser_len));

    p_done_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && ser_done) |=> done_flag);

    p_disable_drops_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pend);

endmodule

bind lapd_tx_sched lapd_tx_sched_chk #(
    .LEN_SHORT (LEN_SHORT),
    .LEN_LONG  (LEN_LONG),
    .LEN_W     (LEN_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .state     (fsm_state),
    .pend      (fsm_pend),
    .ser_start (ser_start),
    .ser_done  (ser_done),
    .ser_len   (ser_len),
    .done_flag (done_flag)
);

// File: tb/lapd_tx_sched_tb.sv
`timescale 1ns/1ps
module lapd_tx_sched_tb_top;
    localparam int LEN_W = 7;
    localparam logic [7:0] A_CFG  = 8'h33;
    localparam logic [7:0] A_STAT = 8'h34;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]       reg_addr = 8'h00, reg_wdata = 8'h00;
    logic [7:0]       reg_rdata;
    logic             send_cmd = 1'b0, sec_tick = 1'b0, ser_busy = 1'b0, ser_done = 1'b0;
    logic             ser_start;
    logic [LEN_W-1:0] ser_len;
    logic             done_flag;

    int checks = 0;
    int errors = 0;
    int n_start = 0;

    always #2.5 clk = ~clk;

    lapd_tx_sched dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .send_cmd(send_cmd), .sec_tick(sec_tick), .ser_busy(ser_busy),
        .ser_done(ser_done), .ser_start(ser_start), .ser_len(ser_len),
        .done_flag(done_flag)
    );

    always @(posedge clk) if (rst_n && ser_start) n_start <= n_start + 1;

    // {cfg byte, expected length}
    localparam logic [15:0] VEC [4] = '{
        {8'h01, 8'd76}, {8'h03, 8'd82}, {8'h0B, 8'd82}, {8'h09, 8'd76}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        reg_addr = A_CFG; reg_wdata = v; reg_wr = 1'b1;
        cyc(); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1; #1; v = reg_rdata;
        cyc(); reg_rd = 1'b0;
    endtask

    task automatic pulse_send(); send_cmd = 1'b1; cyc(); send_cmd = 1'b0; endtask
    task automatic pulse_tick(); sec_tick = 1'b1; cyc(); sec_tick = 1'b0; endtask
    task automatic pulse_done(); ser_done = 1'b1; cyc(); ser_done = 1'b0; endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int base;
        cyc(3);
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        reg_addr = A_CFG; #1;
        chk(reg_rdata == 8'h08, "R1 cfg reset", reg_rdata, 8'h08);
        chk(ser_start == 1'b0, "R1 start low", ser_start, 0);
        chk(done_flag == 1'b0, "R1 done low", done_flag, 0);

        // Table walk: R4 length and start, R9 flag set/clear
        for (int k = 0; k < 4; k++) begin
            wr_cfg(8'h00);
            wr_cfg(VEC[k][15:8]);
            pulse_send();
            chk(ser_start == 1'b1, "R4 start", ser_start, 1);
            chk(ser_len == VEC[k][LEN_W-1:0], "R4 len", ser_len, VEC[k][7:0]);
            cyc();
            chk(ser_start == 1'b0, "R4 single pulse", ser_start, 0);
            pulse_done();
            chk(done_flag == 1'b1, "R9 flag set", done_flag, 1);
            rd(A_STAT, v);
            chk(v[0] == 1'b1, "R9 status bit0", v[0], 1);
            chk(done_flag == 1'b0, "R9 flag cleared by read", done_flag, 0);
        end

        // R2 unused bits
        wr_cfg(8'hFF);
        rd(A_CFG, v);
        chk(v == 8'h0B, "R2 unused bits zero", v, 8'h0B);

        // R3 disabled send ignored
        wr_cfg(8'h00);
        base = n_start;
        pulse_send(); cyc(3);
        chk(n_start == base, "R3 no start while disabled", n_start - base, 0);

        // R5 one-shot: ticks after completion start nothing
        wr_cfg(8'h01);
        pulse_send(); cyc(); pulse_done();
        base = n_start;
        pulse_tick(); cyc(); pulse_tick(); cyc(2);
        chk(n_start == base, "R5 one-shot stops", n_start - base, 0);

        // R6 repeat, R10 send while busy ignored
        wr_cfg(8'h09);
        pulse_send(); cyc();
        base = n_start;
        pulse_send(); cyc(2);
        chk(n_start == base, "R10 send in flight ignored", n_start - base, 0);
        rd(A_STAT, v);
        chk(v[1] == 1'b1, "R9 busy bit", v[1], 1);
        pulse_done();
        cyc(2);
        chk(ser_start == 1'b0, "R6 waits for tick", ser_start, 0);
        pulse_tick();
        chk(ser_start == 1'b1, "R6 tick restarts", ser_start, 1);
        chk(ser_len == 7'd76, "R6 len", ser_len, 76);
        cyc();

        // R7 multiple ticks coalesce into one pending retransmission
        pulse_tick(); cyc(); pulse_tick();
        base = n_start;
        pulse_done();
        chk(ser_start == 1'b1, "R7 immediate retransmit", ser_start, 1);
        cyc();
        pulse_done();
        cyc(3);
        chk(n_start == base + 1, "R7 only one pending", n_start - base, 1);

        // R8 disable cancels pending, in-flight message completes
        rd(A_STAT, v);
        pulse_tick(); cyc();
        pulse_tick();
        wr_cfg(8'h08);
        base = n_start;
        pulse_done();
        chk(done_flag == 1'b1, "R8 in-flight completes", done_flag, 1);
        cyc(2); pulse_tick(); cyc(2);
        chk(n_start == base, "R8 pending cancelled", n_start - base, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule